// File: doc/BRIEF.md
# Banyan Latin-Square Total-Exchange Scheduler

This block carries out a complete personalised exchange among `N` ports (a power of two) over a banyan fabric. The fabric has `M = log2(N)` columns of 2x2 switches, with fixed bit-permute wiring between adjacent columns. A pulse on `start` opens a run of exactly `N` slots. In each slot every input port presents one word, and the fabric routes all `N` words at once to `N` distinct outputs. Each switch column is either straight or crossed, and the slot counter sets that choice directly. After `N` slots every input has reached every output exactly once, so the slot-by-mapping table forms a Latin square.

Each output word comes with the index of the input it came from. The fabric itself is combinational. Its result is registered, so the words a port presents in slot `k` appear on the outputs one clock later, with `out_valid` high. `done` pulses together with the last slot's output. A new `start` at any point restarts the run at slot 0.

Top module: `banyan_xchg_sched`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` and `done` are 0 until a start is accepted.
- R2: A `start` sampled at clock edge e gives `out_valid` high after edges e+1 through e+N, which is exactly N consecutive cycles when no other start intervenes.
- R3: In slot k, column i is crossed (it exchanges each even position with the next odd one) exactly when bit (M-1-i) of k is 1. The wiring after column j swaps position bit 0 with bit j+1. A word entering at port p passes column 0, wiring 0, column 1, and so on, ending at column M-1. The word on port p in slot k appears on the resulting output one cycle later.
- R4: With N = 8, slot 2 sends inputs 0..7 to outputs 4, 6, 0, 2, 5, 7, 1, 3.
- R5: Output o's field `dsrc[o*M +: M]` holds the index of the input whose word is on `dout[o*W +: W]`.
- R6: In every valid cycle the N source tags are all different. Over one complete run, every (source, destination) pair occurs exactly once.
- R7: `done` is high for one cycle only, in the cycle that carries the output of slot N-1.
- R8: A `start` sampled while a run is in progress makes the next slot 0, and the run then continues for N more slots.
- R9: After a `done` that no start extends, `out_valid` drops to 0 and stays 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins or restarts a run at slot 0 |
| din | input | N*W | Per-port words; port p occupies bits p*W +: W |
| out_valid | output | 1 | Registered outputs hold a routed slot |
| dout | output | N*W | Per-output words; output o occupies bits o*W +: W |
| dsrc | output | N*M | Per-output source index; output o occupies bits o*M +: M |
| done | output | 1 | One-cycle pulse with the last slot of a run |

## Verification
On every cycle, the embedded assertions check three things. The outputs of a valid cycle carry a full set of distinct source tags. `done` is a lone pulse that coincides with valid data. The output latency is fixed at two edges after a start, and a run that no start extends ends cleanly. Only the bench's scenarios can show the rest. That covers the exact slot-to-mapping order of the fabric, including the eight-port slot-2 row. It also covers data integrity along each route and that a full run covers every source/destination pair exactly once. The restart and back-to-back cases show the run lengths of N+3 and 2N cycles.

// File: rtl/banyan_xchg_sched.sv
module banyan_xchg_sched #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int M = $clog2(N),
  localparam int LW = W + M
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] din,
  output logic           out_valid,
  output logic [N*W-1:0] dout,
  output logic [N*M-1:0] dsrc,
  output logic           done
);

  function automatic int swap_b0(input int p, input int b);
    int lo;
    int hi;
    int r;
    lo = p & 1;
    hi = (p >> b) & 1;
    r  = p & ~(1 | (1 << b));
    return r | hi | (lo << b);
  endfunction

  localparam logic [M-1:0] LAST = M'(N - 1);

  logic          busy;
  logic [M-1:0]  cnt;
  logic [M-1:0]  xch;
  logic [LW-1:0] pre  [M][N];
  logic [LW-1:0] post [M][N];
  logic [W-1:0]  dat_r [N];
  logic [M-1:0]  src_r [N];
  logic          vld_r;
  logic          done_r;

  genvar i, s, p;
  generate
    for (p = 0; p < N; p++) begin : g_entry
      assign pre[0][p] = {M'(p), din[p*W +: W]};
    end
    for (i = 0; i < M; i++) begin : g_col
      assign xch[i] = cnt[M-1-i];
      for (s = 0; s < N/2; s++) begin : g_sw
        assign post[i][2*s]   = xch[i] ? pre[i][2*s+1] : pre[i][2*s];
        assign post[i][2*s+1] = xch[i] ? pre[i][2*s]   : pre[i][2*s+1];
      end
      if (i < M - 1) begin : g_wire
        for (p = 0; p < N; p++) begin : g_link
          localparam int D = swap_b0(p, i + 1);
          assign pre[i+1][D] = post[i][p];
        end
      end
    end
    for (p = 0; p < N; p++) begin : g_out
      assign dout[p*W +: W] = dat_r[p];
      assign dsrc[p*M +: M] = src_r[p];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      vld_r  <= 1'b0;
      done_r <= 1'b0;
      for (int o = 0; o < N; o++) begin
        dat_r[o] <= '0;
        src_r[o] <= '0;
      end
    end else begin
      vld_r  <= busy;
      done_r <= busy && (cnt == LAST);
      if (busy) begin
        for (int o = 0; o < N; o++) begin
          dat_r[o] <= post[M-1][o][W-1:0];
          src_r[o] <= post[M-1][o][LW-1:W];
        end
      end
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == LAST) busy <= 1'b0;
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign out_valid = vld_r;
  assign done      = done_r;

  logic [N-1:0] seen;
  always_comb begin
    seen = '0;
    for (int o = 0; o < N; o++) seen[src_r[o]] = 1'b1;
  end

  // R6
  tags_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (&seen));

  // R2
  start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##2 out_valid);

  // R7
  done_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  run_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(start)) |=> !out_valid);

endmodule

// File: tb/banyan_xchg_sched_test.sv
module banyan_xchg_sched_test;
  localparam int N = 8;
  localparam int W = 16;
  localparam int M = $clog2(N);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] din = '0;
  logic           out_valid;
  logic [N*W-1:0] dout;
  logic [N*M-1:0] dsrc;
  logic           done;

  banyan_xchg_sched #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .out_valid(out_valid), .dout(dout), .dsrc(dsrc), .done(done)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pairs [N][N];
  int vcnt = 0;
  int dcnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int dest(input int j, input int k);
    int pos;
    pos = j;
    for (int i = 0; i < M; i++) begin
      if (((k >> (M - 1 - i)) & 1) == 1) pos = pos ^ 1;
      if (i < M - 1) begin
        int b0;
        int bh;
        b0 = pos & 1;
        bh = (pos >> (i + 1)) & 1;
        pos = (pos & ~(1 | (1 << (i + 1)))) | bh | (b0 << (i + 1));
      end
    end
    return pos;
  endfunction

  // per-cycle input words
  always @(posedge clk) begin
    #2;
    cyc++;
    for (int j = 0; j < N; j++) din[j*W +: W] = W'(cyc * 101 + j * 37 + 5);
  end

  // behavioural reference
  bit m_busy = 0;
  int m_cnt = 0;
  bit e_vld = 0;
  bit e_done = 0;
  int e_slot = 0;
  int e_src [N];
  int e_dat [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; e_vld = 0; e_done = 0;
    end else begin
      e_vld = m_busy;
      e_done = m_busy && (m_cnt == N - 1);
      if (m_busy) begin
        e_slot = m_cnt;
        for (int j = 0; j < N; j++) begin
          e_src[dest(j, m_cnt)] = j;
          e_dat[dest(j, m_cnt)] = int'(din[j*W +: W]);
        end
      end
      if (start) begin
        m_busy = 1; m_cnt = 0;
      end else if (m_busy) begin
        if (m_cnt == N - 1) m_busy = 0;
        m_cnt++;
      end
    end
  end

  int row2 [8] = '{4, 6, 0, 2, 5, 7, 1, 3};

  always @(negedge clk) begin
    if (rst_n) begin
      check(out_valid == e_vld, "R2/R9 valid", out_valid, e_vld);
      check(done == e_done, "R7 done", done, e_done);
      if (out_valid) vcnt++;
      if (done) dcnt++;
      if (e_vld && out_valid) begin
        for (int o = 0; o < N; o++) begin
          int s;
          s = int'(dsrc[o*M +: M]);
          check(s == e_src[o], "R5 source tag", s, e_src[o]);
          check(int'(dout[o*W +: W]) == e_dat[o], "R3 routed data", int'(dout[o*W +: W]), e_dat[o]);
          pairs[s][o]++;
        end
        if (N == 8 && e_slot == 2)
          for (int j = 0; j < 8; j++)
            check(int'(dsrc[row2[j]*M +: M]) == j, "R4 slot-2 row", int'(dsrc[row2[j]*M +: M]), j);
      end
    end
  end

  task automatic pulse();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic clear_stats();
    for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) pairs[a][b] = 0;
    vcnt = 0; dcnt = 0;
  endtask

  task automatic check_pairs(input int want, input string req);
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        check(pairs[a][b] == want, req, pairs[a][b], want);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);

    clear_stats();
    pulse();
    repeat (N + 4) @(posedge clk);
    @(negedge clk); #1;
    check(vcnt == N, "R2 run length", vcnt, N);
    check(dcnt == 1, "R7 done count", dcnt, 1);
    check_pairs(1, "R6 pair coverage");
    check(out_valid == 1'b0, "R9 idle after run", out_valid, 0);

    clear_stats();
    pulse();
    repeat (1) @(posedge clk);
    pulse();
    repeat (N + 4) @(posedge clk);
    @(negedge clk); #1;
    check(vcnt == N + 3, "R8 restart length", vcnt, N + 3);
    check(dcnt == 1, "R8 restart done count", dcnt, 1);

    clear_stats();
    pulse();
    repeat (N - 2) @(posedge clk);
    pulse();
    repeat (N + 4) @(posedge clk);
    @(negedge clk); #1;
    check(vcnt == 2 * N, "R7 back-to-back length", vcnt, 2 * N);
    check(dcnt == 2, "R7 back-to-back done count", dcnt, 2);
    check_pairs(2, "R6 two-run coverage");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule